// File: doc/BRIEF.md
# Register-Mapped Integer Divide and Square-Root Engine

This block gives a small processor without hardware divide or square-root instructions a bus-attached arithmetic unit. Software writes operands into registers through a single-cycle read/write port. A write to the right register launches either a restoring division, signed or unsigned, of one W-bit value by another, or a digit-by-digit integer square root of a W-bit radicand. While the engine iterates, a busy flag is set. When the flag clears, the single shared result register holds the answer.

The control register selects signed or unsigned arithmetic and chooses whether the quotient or the remainder lands in the result register. It can also turn off the automatic launch on a divisor write, so that division waits for an explicit start bit. A zero divisor is flagged, and it can be made to raise an error strobe when the result is read. Any launch, whether division or square root, aborts whatever operation is still running.

Top module: `divsqrt_unit`

Word addresses: 0 control/status, 1 dividend, 2 divisor, 3 radicand (write-only, reads 0), 4 result. Control/status bits: bit 0 is start when written (1 launches a division) and busy when read; bit 1 unsigned select; bit 2 remainder select; bit 3 zero-error enable; bit 4 manual start; bit 5 zero-divisor flag (read-only); bit 6 division active (read-only); bit 7 square root active (read-only). All other bits read 0.

## Requirements
- R1: After reset, the control/status word and the result register both read 0.
- R2: When bit 4 is 0, a write to address 2 launches a division using the stored dividend and the written divisor. Busy reads 1 in the cycle that follows the write.
- R3: When bit 4 is 1, a divisor write does not launch: busy stays 0 and the result is unchanged. A control write with bit 0 set launches the division in either mode, and it uses the bits 1 and 2 from that same write.
- R4: In unsigned mode (bit 1 = 1), the result is the quotient floor(a/b) when bit 2 = 0 and the remainder a mod b when bit 2 = 1.
- R5: In signed mode (bit 1 = 0), the quotient is truncated toward zero, the remainder carries the dividend's sign, and results wrap to W bits (the most negative value divided by -1 gives the most negative value).
- R6: A zero divisor sets bit 5 and completes after one busy cycle. The quotient is all ones and the remainder equals the raw dividend. The next division with a non-zero divisor clears bit 5.
- R7: A read of address 4 raises rd_err in the same cycle if and only if bits 3 and 5 are both 1. Without that error, the read returns the result register as normal.
- R8: A write to address 3 launches a square root. After W/2 busy cycles, the result holds floor(sqrt(radicand)), zero-extended.
- R9: A launch while busy abandons the running operation. Only the new operation's result appears, after its own full latency measured from the new launch.
- R10: A division with a non-zero divisor keeps busy at 1 for exactly W cycles. The result register is stable whenever the unit is idle and nothing is launched.
- R11: While busy, exactly one of bit 6 (division) and bit 7 (square root) is 1, matching the operation that was launched last. Both read 0 when the unit is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write strobe, sampled at the rising edge |
| rd_en | input | 1 | Read strobe, combinational read |
| addr | input | 3 | Word address |
| wdata | input | W | Write data |
| rdata | output | W | Read data, 0 when rd_en is low |
| rd_err | output | 1 | Error on a result read after a zero-divisor division |

## Verification
If the partial remainder or the trial-subtraction decision goes wrong, the first division that exercises the damaged bit returns a wrong quotient or remainder as soon as busy clears, so a sweep of many operands exposes it within a few operations. If the iteration counter or the abort path is wrong, busy stays high for the wrong number of cycles, or a result from an abandoned operation leaks out. The bench measures every busy window cycle by cycle. A wrong sign-correction or zero-divisor flag shows up in the signed and zero-divisor corners. Those corners appear in the sweep, and the zero-divisor case is also read through the error strobe.

// File: rtl/divsqrt_unit.sv
module divsqrt_unit #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic         rd_en,
  input  logic [2:0]   addr,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] rdata,
  output logic         rd_err
);
  localparam int CW = $clog2(W + 1);
  localparam logic [2:0] A_CTL = 3'd0, A_DEND = 3'd1, A_DSOR = 3'd2, A_RAD = 3'd3, A_RES = 3'd4;
  localparam logic [CW-1:0] DIV_N = CW'(W);
  localparam logic [CW-1:0] SQ_N  = CW'(W / 2);

  logic uns_q, rem_q, zen_q, man_q, dz_q;
  logic [W-1:0] dend_q, dsor_q, res_q;
  logic busy_q, op_sqrt_q, run_zero, run_rem, run_neg_q, run_neg_r;
  logic [CW-1:0] cnt_q;
  logic [W:0]   pr_q;
  logic [W-1:0] qt_q, dv_q;
  logic [W-1:0] sq_op, sq_rt, sq_bit;

  wire wr_ctl     = wr_en && addr == A_CTL;
  wire launch_div = (wr_ctl && wdata[0]) || (wr_en && addr == A_DSOR && !man_q);
  wire launch_sq  = wr_en && addr == A_RAD;
  wire launch     = launch_div || launch_sq;
  wire [W-1:0] dsor_in = (wr_en && addr == A_DSOR) ? wdata : dsor_q;
  wire uns_in = wr_ctl ? wdata[1] : uns_q;
  wire rem_in = wr_ctl ? wdata[2] : rem_q;
  wire zero_in = dsor_in == '0;
  wire [W-1:0] dend_mag = (!uns_in && dend_q[W-1]) ? -dend_q : dend_q;
  wire [W-1:0] dsor_mag = (!uns_in && dsor_in[W-1]) ? -dsor_in : dsor_in;

  wire [W:0]   shifted = {pr_q[W-1:0], qt_q[W-1]};
  wire [W:0]   diff    = shifted - {1'b0, dv_q};
  wire         take    = !diff[W];
  wire [W:0]   pr_n    = take ? diff : shifted;
  wire [W-1:0] qt_n    = {qt_q[W-2:0], take};
  wire [W-1:0] quo_f   = run_neg_q ? -qt_n : qt_n;
  wire [W-1:0] rem_f   = run_neg_r ? -pr_n[W-1:0] : pr_n[W-1:0];

  wire [W-1:0] trial = sq_rt + sq_bit;
  wire         sq_ge = sq_op >= trial;
  wire [W-1:0] rt_n  = sq_ge ? ((sq_rt >> 1) + sq_bit) : (sq_rt >> 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      {uns_q, rem_q, zen_q, man_q, dz_q} <= '0;
      dend_q <= '0; dsor_q <= '0; res_q <= '0;
      {busy_q, op_sqrt_q, run_zero, run_rem, run_neg_q, run_neg_r} <= '0;
      cnt_q <= '0; pr_q <= '0; qt_q <= '0; dv_q <= '0;
      sq_op <= '0; sq_rt <= '0; sq_bit <= '0;
    end else begin
      if (wr_ctl) {man_q, zen_q, rem_q, uns_q} <= wdata[4:1];
      if (wr_en && addr == A_DEND) dend_q <= wdata;
      if (wr_en && addr == A_DSOR) dsor_q <= wdata;
      if (launch_div) begin
        busy_q    <= 1'b1;
        op_sqrt_q <= 1'b0;
        dz_q      <= zero_in;
        run_zero  <= zero_in;
        run_rem   <= rem_in;
        run_neg_q <= !uns_in && (dend_q[W-1] ^ dsor_in[W-1]);
        run_neg_r <= !uns_in && dend_q[W-1];
        pr_q      <= '0;
        qt_q      <= zero_in ? dend_q : dend_mag;
        dv_q      <= dsor_mag;
        cnt_q     <= DIV_N;
      end else if (launch_sq) begin
        busy_q    <= 1'b1;
        op_sqrt_q <= 1'b1;
        run_zero  <= 1'b0;
        sq_op     <= wdata;
        sq_rt     <= '0;
        sq_bit    <= W'(1) << (W - 2);
        cnt_q     <= SQ_N;
      end else if (busy_q) begin
        if (!op_sqrt_q && run_zero) begin
          busy_q <= 1'b0;
          cnt_q  <= '0;
          res_q  <= run_rem ? qt_q : '1;
        end else begin
          cnt_q <= cnt_q - 1'b1;
          if (op_sqrt_q) begin
            sq_op  <= sq_ge ? sq_op - trial : sq_op;
            sq_rt  <= rt_n;
            sq_bit <= sq_bit >> 2;
          end else begin
            pr_q <= pr_n;
            qt_q <= qt_n;
          end
          if (cnt_q == 1) begin
            busy_q <= 1'b0;
            res_q  <= op_sqrt_q ? rt_n : (run_rem ? rem_f : quo_f);
          end
        end
      end
    end
  end

  always_comb begin
    rdata = '0;
    if (rd_en) begin
      case (addr)
        A_CTL:  rdata[7:0] = {busy_q && op_sqrt_q, busy_q && !op_sqrt_q, dz_q, man_q, zen_q, rem_q, uns_q, busy_q};
        A_DEND: rdata = dend_q;
        A_DSOR: rdata = dsor_q;
        A_RES:  rdata = res_q;
        default: rdata = '0;
      endcase
    end
  end

  assign rd_err = rd_en && addr == A_RES && zen_q && dz_q;

  a_r2_launch_busy: assert property (@(posedge clk) disable iff (!rst_n) launch |=> busy_q);
  a_r6_zero_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !op_sqrt_q && run_zero && !launch) |=> !busy_q);
  a_r10_idle_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_q && !launch) |=> $stable(res_q));
  a_r10_count_live: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> (cnt_q != 0 && cnt_q <= DIV_N));
  a_r8_root_width: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && op_sqrt_q && cnt_q == 1 && !launch) |=> (res_q >> (W / 2)) == '0);
endmodule

// File: tb/tb_divsqrt_unit.sv
module tb_divsqrt_unit;
  localparam int W = 8;
  logic clk = 0, rst_n = 0, wr_en = 0, rd_en = 0, rd_err;
  logic [2:0] addr = 0;
  logic [W-1:0] wdata = 0, rdata;
  int checks = 0, errors = 0;

  divsqrt_unit #(.W(W)) dut (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .rd_err(rd_err));

  always #2 clk = ~clk;

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [W-1:0] d);
    @(negedge clk); wr_en = 1; addr = a; wdata = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [W-1:0] d, output logic e);
    rd_en = 1; addr = a; #1; d = rdata; e = rd_err; rd_en = 0;
  endtask

  task automatic wait_done(output int n);
    logic [W-1:0] s; logic e;
    n = 0;
    rd(3'd0, s, e);
    while (s[0]) begin
      @(negedge clk); n++;
      rd(3'd0, s, e);
    end
  endtask

  function automatic int exp_div(input int a, input int b, input bit u, input bit r);
    int sa, sb, q, m;
    if (b == 0) return r ? a : 255;
    sa = (!u && a >= 128) ? a - 256 : a;
    sb = (!u && b >= 128) ? b - 256 : b;
    q = sa / sb; m = sa % sb;
    return r ? (m & 255) : (q & 255);
  endfunction

  function automatic int isqrt(input int x);
    int r = 0;
    while ((r + 1) * (r + 1) <= x) r++;
    return r;
  endfunction

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [W-1:0] d; logic e; int n;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    rd(3'd0, d, e); check("R1 status", d, 0);
    rd(3'd4, d, e); check("R1 result", d, 0);

    for (int i = 0; i < 18; i++) begin
      for (int j = 0; j < 256; j++) begin
        int a; bit u, r;
        a = (i < 16) ? i * 17 : (i == 16 ? 128 : 127);
        u = ((i + j) & 1) != 0; r = ((i + j) & 2) != 0;
        wr(3'd0, {5'b0, r, u, 1'b0});
        wr(3'd1, W'(a));
        wr(3'd2, W'(j));
        wait_done(n);
        if (n != ((j == 0) ? 1 : W)) check(j == 0 ? "R6 latency" : "R10 latency", n, (j == 0) ? 1 : W);
        else checks++;
        rd(3'd4, d, e);
        if (d != exp_div(a, j, u, r)) check(j == 0 ? "R6 value" : (u ? "R4 value" : "R5 value"), d, exp_div(a, j, u, r));
        else checks++;
      end
    end

    for (int x = 0; x < 256; x++) begin
      wr(3'd3, W'(x));
      wait_done(n);
      if (n != W / 2) check("R8 latency", n, W / 2); else checks++;
      rd(3'd4, d, e);
      if (d != isqrt(x)) check("R8 root", d, isqrt(x)); else checks++;
    end

    wr(3'd0, 8'h02); wr(3'd1, 8'd45); wr(3'd2, 8'd6);
    wait_done(n);
    wr(3'd0, 8'h12); wr(3'd1, 8'd100); wr(3'd2, 8'd7);
    rd(3'd0, d, e); check("R3 no launch busy", d[0], 0);
    rd(3'd4, d, e); check("R3 result kept", d, 7);
    wr(3'd0, 8'h13);
    rd(3'd0, d, e); check("R3 start busy", d[0], 1);
    check("R11 div flag", d[7:6], 2'b01);
    wait_done(n);
    rd(3'd4, d, e); check("R3 started quotient", d, 14);
    rd(3'd0, d, e); check("R11 idle flags", d[7:6], 0);

    wr(3'd0, 8'h0A); wr(3'd1, 8'd9); wr(3'd2, 8'd0);
    wait_done(n);
    rd(3'd0, d, e); check("R6 zero flag", d[5], 1);
    rd(3'd4, d, e); check("R7 error on", e, 1);
    wr(3'd0, 8'h02);
    rd(3'd4, d, e); check("R7 error off", e, 0);
    check("R7 value", d, 255);
    wr(3'd0, 8'h0A); wr(3'd2, 8'd4);
    wait_done(n);
    rd(3'd0, d, e); check("R6 flag cleared", d[5], 0);
    rd(3'd4, d, e); check("R7 no error", e, 0);
    check("R7 value2", d, 2);

    wr(3'd0, 8'h02); wr(3'd1, 8'd200); wr(3'd2, 8'd3);
    @(negedge clk); @(negedge clk);
    wr(3'd3, 8'd100);
    rd(3'd0, d, e); check("R11 sqrt flag", d[7:6], 2'b10);
    wait_done(n);
    check("R9 abort latency", n, W / 2);
    rd(3'd4, d, e); check("R9 abort root", d, 10);
    wr(3'd3, 8'd255);
    wr(3'd0, 8'h04); wr(3'd1, 8'd50);
    wr(3'd2, 8'd7);
    wait_done(n);
    check("R9 second latency", n, W);
    rd(3'd4, d, e); check("R9 second remainder", d, 1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule